// File: doc/BRIEF.md
# Byte-Packing Duplex Data Queue

This block sits between a bus-facing data port and a 128-bit block-processing core. It holds two 64-byte queues. The ingress queue takes writes of 8, 16 or 32 bits and packs them into 32-bit words, least significant byte first. The core removes data from it in 128-bit blocks, and only when four whole words are waiting. The egress queue takes 128-bit result blocks from the core and is drained one 32-bit word at a time.

Each queue reports its fill level in bytes, four level flags and a watermark flag, and has two sticky error flags. It also drives a single-request line and a burst-request line for an external DMA engine. Both request lines obey an enable, and a burst-only option silences the single line.

All three data paths use valid/ready handshakes, with a rule that differs from the usual one. A transfer happens on a clock edge where both valid and ready are high. Valid high while ready is low does not hold the data: the write or push is dropped and the matching overflow flag is set. The request is also dropped when the core asks for a block or the reader asks for a word while valid is low, and the matching underrun flag is set. Driving `en` low flushes everything and clears the sticky flags.

Top module: `bpk_duplex_fifo`

## Requirements
- R1: `wr_size` selects the width of a write: 0 is a byte (`wr_data[7:0]`), 1 is a halfword (`wr_data[15:0]`), and 2 or 3 is a full word. Unused upper lanes are ignored. Bytes are packed in order of arrival, and the first byte lands in bits 7..0 of a word.
- R2: `in_fill` counts stored bytes, including bytes of a partly packed word, from 0 to 64. `out_fill` counts stored bytes in steps of 4.
- R3: `wr_ready` is high only when `en` is high and the fill level plus the size of the offered write does not exceed 64. An offered write while `wr_ready` is low leaves the queue unchanged and sets ingress overflow (`in_flags[5]`).
- R4: `blk_valid` is high when at least four whole words are stored. `blk_data[31:0]` holds the oldest word. A block request with `blk_valid` low returns zero and sets ingress underrun (`in_flags[6]`).
- R5: `res_ready` is high when at least 16 bytes are free in the egress queue. A push offered while `res_ready` is low is dropped and sets egress overflow (`out_flags[5]`).
- R6: `rd_valid` is high while the egress queue holds a word. Words leave in the order `res_data[31:0]`, `[63:32]`, `[95:64]`, `[127:96]`. A read request with `rd_valid` low returns zero and sets egress underrun (`out_flags[6]`).
- R7: In each flags vector, bit 0 is empty, bit 1 is not-empty, bit 2 is full (64 bytes) and bit 3 is not-full.
- R8: `in_flags[4]` is high when `in_fill` is less than or equal to `in_wm_lvl`.
- R9: `out_flags[4]` is high when `out_fill` is strictly greater than `out_wm_lvl`.
- R10: The overflow and underrun flags stay set while `en` is high and clear only when `en` is low.
- R11: A queue's burst request is high when its DMA enable is set and its free space (ingress) or stored bytes (egress) is at least 16. Its single request needs at least 4 bytes and is held low when burst-only is set.
- R12: While `en` is low, both queues are empty, any partly packed bytes are discarded, and all ready, valid and request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Module enable; low flushes both queues |
| in_wm_lvl | input | 6 | Ingress watermark threshold in bytes |
| out_wm_lvl | input | 6 | Egress watermark threshold in bytes |
| in_dma_en | input | 1 | Ingress DMA request enable |
| in_dma_burst_only | input | 1 | Ingress: burst requests only |
| out_dma_en | input | 1 | Egress DMA request enable |
| out_dma_burst_only | input | 1 | Egress: burst requests only |
| wr_valid | input | 1 | Write offered |
| wr_size | input | 2 | Write width code |
| wr_data | input | 32 | Write data, right-aligned |
| wr_ready | output | 1 | Offered write fits |
| blk_valid | output | 1 | A 128-bit block is available |
| blk_ready | input | 1 | Core takes a block |
| blk_data | output | 128 | Oldest block, zero when not valid |
| res_valid | input | 1 | Core offers a result block |
| res_data | input | 128 | Result block |
| res_ready | output | 1 | Room for a result block |
| rd_valid | output | 1 | An egress word is available |
| rd_ready | input | 1 | Reader takes a word |
| rd_data | output | 32 | Oldest egress word, zero when not valid |
| in_fill | output | 7 | Ingress fill level in bytes |
| in_flags | output | 7 | Ingress status flags |
| out_fill | output | 7 | Egress fill level in bytes |
| out_flags | output | 7 | Egress status flags |
| in_dreq_single | output | 1 | Ingress single DMA request |
| in_dreq_burst | output | 1 | Ingress burst DMA request |
| out_dreq_single | output | 1 | Egress single DMA request |
| out_dreq_burst | output | 1 | Egress burst DMA request |

## Verification
A wrong packing offset or pending-byte count does not show on `in_fill` alone. It shows as a scrambled or shifted `blk_data` once the sixteenth byte arrives, and it skews every later block. A ring pointer error shows in the very next block or word read out. A count error shows at once as a wrong fill level, and as flags or handshake lines that switch at the wrong byte. A sticky flag that clears itself, or one that survives a flush, is visible one cycle after the event or after the `en` pulse.

// File: rtl/bpk_pkg.sv
package bpk_pkg;
  // flag vector bit positions
  localparam int FL_EMPTY = 0;
  localparam int FL_NEMPTY = 1;
  localparam int FL_FULL = 2;
  localparam int FL_NFULL = 3;
  localparam int FL_WM = 4;
  localparam int FL_OVF = 5;
  localparam int FL_UDR = 6;
  localparam int FL_W = 7;

  // number of bytes carried by a write of the given width code
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0: size_bytes = 3'd1;
      2'd1: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/bpk_word_ring.sv
module bpk_word_ring #(
  parameter int DEPTH = 16,
  parameter int IN_N = 1,
  parameter int OUT_N = 4,
  parameter int W = 32,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [IN_N*W-1:0]  push_data,
  input  logic               pop,
  output logic [OUT_N*W-1:0] pop_data,
  output logic [CW-1:0]      count
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      wp <= '0;
      rp <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp <= wp + PW'(IN_N);
      if (pop) rp <= rp + PW'(OUT_N);
      cnt_q <= cnt_q + (push ? CW'(IN_N) : '0) - (pop ? CW'(OUT_N) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) begin
      for (int i = 0; i < IN_N; i++) mem[wp + PW'(i)] <= push_data[i*W +: W];
    end
  end

  for (genvar g = 0; g < OUT_N; g++) begin : g_rd
    assign pop_data[g*W +: W] = mem[rp + PW'(g)];
  end

  assign count = cnt_q;

  AST_RING_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |-> (cnt_q <= CW'(DEPTH - IN_N))); // R3
  AST_RING_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> (cnt_q >= CW'(OUT_N))); // R4
endmodule

// File: rtl/bpk_packer.sv
module bpk_packer
  import bpk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        take,
  input  logic [1:0]  size,
  input  logic [31:0] data,
  output logic        word_push,
  output logic [31:0] word,
  output logic [1:0]  pend_cnt
);
  logic [23:0] pend_q;
  logic [1:0]  cnt_q;
  logic [2:0]  nb;
  logic [31:0] lanes;
  logic [55:0] merged;
  logic [2:0]  total;

  always_comb begin
    nb = size_bytes(size);
    case (nb)
      3'd1: lanes = {24'h0, data[7:0]};
      3'd2: lanes = {16'h0, data[15:0]};
      default: lanes = data;
    endcase
    merged = {32'h0, pend_q} | ({24'h0, lanes} << {cnt_q, 3'b000});
    total = {1'b0, cnt_q} + nb;
  end

  assign word_push = take && (total >= 3'd4);
  assign word = merged[31:0];
  assign pend_cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      pend_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      if (total >= 3'd4) begin
        pend_q <= merged[55:32];
        cnt_q <= 2'(total - 3'd4);
      end else begin
        pend_q <= merged[23:0];
        cnt_q <= total[1:0];
      end
    end
  end

  AST_PACK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == 2'd0) |-> (pend_q == 24'h0)); // R1
endmodule

// File: rtl/bpk_qstat.sv
module bpk_qstat
  import bpk_pkg::*;
#(
  parameter int CAP = 64,
  parameter int FW = 7,
  parameter int WMW = 6,
  parameter int BLK = 16,
  parameter int WB = 4,
  parameter bit IS_OUT = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [FW-1:0]   fill,
  input  logic [WMW-1:0]  wm_lvl,
  input  logic            ovf_evt,
  input  logic            udr_evt,
  input  logic            dma_en,
  input  logic            burst_only,
  output logic [FL_W-1:0] flags,
  output logic            dreq_single,
  output logic            dreq_burst
);
  logic [FW-1:0] avail;
  logic          wm;
  logic          ovf_q, udr_q;

  if (IS_OUT) begin : g_out
    assign avail = fill;
    assign wm = fill > FW'(wm_lvl);
  end else begin : g_in
    assign avail = FW'(CAP) - fill;
    assign wm = fill <= FW'(wm_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udr_q <= 1'b0;
    end else if (!en) begin
      ovf_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      ovf_q <= ovf_q | ovf_evt;
      udr_q <= udr_q | udr_evt;
    end
  end

  assign flags = {udr_q, ovf_q, wm, fill != FW'(CAP), fill == FW'(CAP),
                  fill != '0, fill == '0};
  assign dreq_burst = en && dma_en && (avail >= FW'(BLK));
  assign dreq_single = en && dma_en && !burst_only && (avail >= FW'(WB));

  AST_STICKY_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && en) |=> ovf_q); // R10
  AST_STICKY_UDR: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_q && en) |=> udr_q); // R10
  AST_DREQ_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_burst && !burst_only) |-> dreq_single); // R11
endmodule

// File: rtl/bpk_duplex_fifo.sv
module bpk_duplex_fifo
  import bpk_pkg::*;
#(
  parameter int DEPTH_BYTES = 64,
  parameter int WM_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [WM_W-1:0] in_wm_lvl,
  input  logic [WM_W-1:0] out_wm_lvl,
  input  logic            in_dma_en,
  input  logic            in_dma_burst_only,
  input  logic            out_dma_en,
  input  logic            out_dma_burst_only,
  input  logic            wr_valid,
  input  logic [1:0]      wr_size,
  input  logic [31:0]     wr_data,
  output logic            wr_ready,
  output logic            blk_valid,
  input  logic            blk_ready,
  output logic [127:0]    blk_data,
  input  logic            res_valid,
  input  logic [127:0]    res_data,
  output logic            res_ready,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [31:0]     rd_data,
  output logic [6:0]      in_fill,
  output logic [6:0]      in_flags,
  output logic [6:0]      out_fill,
  output logic [6:0]      out_flags,
  output logic            in_dreq_single,
  output logic            in_dreq_burst,
  output logic            out_dreq_single,
  output logic            out_dreq_burst
);
  localparam int WORDS = DEPTH_BYTES / 4;
  localparam int BLK_N = 4;
  localparam int CW = $clog2(WORDS + 1);

  logic          clr;
  logic          take, word_push;
  logic [31:0]   packed_word;
  logic [1:0]    pend_cnt;
  logic [CW-1:0] in_cnt, out_cnt;
  logic [127:0]  in_head;
  logic [31:0]   out_head;
  logic          blk_pop, res_push, rd_pop;
  logic [7:0]    in_need;

  assign clr = !en;

  // ingress side
  assign in_fill = 7'({in_cnt, 2'b00}) + 7'(pend_cnt);
  assign in_need = {1'b0, in_fill} + 8'(size_bytes(wr_size));
  assign wr_ready = en && (in_need <= 8'(DEPTH_BYTES));
  assign take = wr_valid && wr_ready;

  bpk_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .size(wr_size),
    .data(wr_data), .word_push(word_push), .word(packed_word), .pend_cnt(pend_cnt)
  );

  bpk_word_ring #(.DEPTH(WORDS), .IN_N(1), .OUT_N(BLK_N), .W(32)) u_in_ring (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(word_push), .push_data(packed_word),
    .pop(blk_pop), .pop_data(in_head), .count(in_cnt)
  );

  assign blk_valid = en && (in_cnt >= CW'(BLK_N));
  assign blk_pop = blk_valid && blk_ready;
  assign blk_data = blk_valid ? in_head : '0;

  bpk_qstat #(.CAP(DEPTH_BYTES), .FW(7), .WMW(WM_W), .IS_OUT(1'b0)) u_in_stat (
    .clk(clk), .rst_n(rst_n), .en(en), .fill(in_fill), .wm_lvl(in_wm_lvl),
    .ovf_evt(en && wr_valid && !wr_ready), .udr_evt(en && blk_ready && !blk_valid),
    .dma_en(in_dma_en), .burst_only(in_dma_burst_only), .flags(in_flags),
    .dreq_single(in_dreq_single), .dreq_burst(in_dreq_burst)
  );

  // egress side
  assign res_ready = en && (out_cnt <= CW'(WORDS - BLK_N));
  assign res_push = res_valid && res_ready;

  bpk_word_ring #(.DEPTH(WORDS), .IN_N(BLK_N), .OUT_N(1), .W(32)) u_out_ring (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(res_push), .push_data(res_data),
    .pop(rd_pop), .pop_data(out_head), .count(out_cnt)
  );

  assign out_fill = 7'({out_cnt, 2'b00});
  assign rd_valid = en && (out_cnt != '0);
  assign rd_pop = rd_valid && rd_ready;
  assign rd_data = rd_valid ? out_head : '0;

  bpk_qstat #(.CAP(DEPTH_BYTES), .FW(7), .WMW(WM_W), .IS_OUT(1'b1)) u_out_stat (
    .clk(clk), .rst_n(rst_n), .en(en), .fill(out_fill), .wm_lvl(out_wm_lvl),
    .ovf_evt(en && res_valid && !res_ready), .udr_evt(en && rd_ready && !rd_valid),
    .dma_en(out_dma_en), .burst_only(out_dma_burst_only), .flags(out_flags),
    .dreq_single(out_dreq_single), .dreq_burst(out_dreq_burst)
  );

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fill <= 7'(DEPTH_BYTES)) && (out_fill <= 7'(DEPTH_BYTES))); // R2
  AST_BLK_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> (in_fill >= 7'd16)); // R4
  AST_DROP_KEEPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_valid && !wr_ready && !blk_ready) |=> (in_fill == $past(in_fill))); // R3
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((in_fill == 7'd0) && (out_fill == 7'd0))); // R12
endmodule

// File: tb/bpk_duplex_fifo_tb.sv
`timescale 1ns/1ps
module bpk_duplex_fifo_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, en;
  logic [5:0] in_wm_lvl, out_wm_lvl;
  logic in_dma_en, in_dma_burst_only, out_dma_en, out_dma_burst_only;
  logic wr_valid, wr_ready, blk_valid, blk_ready, res_valid, res_ready, rd_valid, rd_ready;
  logic [1:0] wr_size;
  logic [31:0] wr_data, rd_data;
  logic [127:0] blk_data, res_data;
  logic [6:0] in_fill, in_flags, out_fill, out_flags;
  logic in_dreq_single, in_dreq_burst, out_dreq_single, out_dreq_burst;

  bpk_duplex_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .in_wm_lvl(in_wm_lvl), .out_wm_lvl(out_wm_lvl),
    .in_dma_en(in_dma_en), .in_dma_burst_only(in_dma_burst_only),
    .out_dma_en(out_dma_en), .out_dma_burst_only(out_dma_burst_only),
    .wr_valid(wr_valid), .wr_size(wr_size), .wr_data(wr_data), .wr_ready(wr_ready),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
    .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .in_fill(in_fill), .in_flags(in_flags), .out_fill(out_fill), .out_flags(out_flags),
    .in_dreq_single(in_dreq_single), .in_dreq_burst(in_dreq_burst),
    .out_dreq_single(out_dreq_single), .out_dreq_burst(out_dreq_burst)
  );

  int total = 0;
  int fails = 0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_size = s; wr_data = d;
    @(negedge clk); wr_valid = 1'b0; #1;
  endtask

  task automatic pop_blk();
    @(negedge clk); blk_ready = 1'b1;
    @(negedge clk); blk_ready = 1'b0; #1;
  endtask

  task automatic push_res(input logic [127:0] d);
    @(negedge clk); res_valid = 1'b1; res_data = d;
    @(negedge clk); res_valid = 1'b0; #1;
  endtask

  task automatic rd_one(output logic [31:0] d);
    @(negedge clk); rd_ready = 1'b1; #1 d = rd_data;
    @(negedge clk); rd_ready = 1'b0; #1;
  endtask

  task automatic flush();
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1; #1;
  endtask

  // {size, data, expected fill, expected blk_valid, expected watermark}
  localparam logic [42:0] VEC [8] = '{
    {2'd0, 32'hDEADBE11, 7'd1,  1'b0, 1'b1},
    {2'd1, 32'hFFFF3322, 7'd3,  1'b0, 1'b1},
    {2'd2, 32'h77665544, 7'd7,  1'b0, 1'b1},
    {2'd0, 32'h12345688, 7'd8,  1'b0, 1'b1},
    {2'd3, 32'hCCBBAA99, 7'd12, 1'b0, 1'b0},
    {2'd1, 32'h0000EEDD, 7'd14, 1'b0, 1'b0},
    {2'd0, 32'h000000FF, 7'd15, 1'b0, 1'b0},
    {2'd0, 32'hA5A5A500, 7'd16, 1'b1, 1'b0}
  };
  localparam logic [127:0] BLK_A = 128'h00FFEEDD_CCBBAA99_88776655_44332211;

  initial begin
    #(200000 * 5);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] w;
    rst_n = 1'b0; en = 1'b1; in_wm_lvl = 6'd8; out_wm_lvl = 6'd8;
    in_dma_en = 1'b0; in_dma_burst_only = 1'b0; out_dma_en = 1'b0; out_dma_burst_only = 1'b0;
    wr_valid = 1'b0; wr_size = 2'd0; wr_data = '0; blk_ready = 1'b0;
    res_valid = 1'b0; res_data = '0; rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;

    // reset state
    chk("R2 reset in_fill", 128'(in_fill), 128'd0);
    chk("R7 reset in_flags", 128'(in_flags), 128'h19);
    chk("R7 reset out_flags", 128'(out_flags), 128'h09);
    chk("R4 reset blk_valid", 128'(blk_valid), 128'd0);
    chk("R6 reset rd_valid", 128'(rd_valid), 128'd0);

    // vector walk: mixed-width packing, fill and ingress watermark
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][42:41], VEC[i][40:9]);
      chk("R2 fill after write", 128'(in_fill), 128'(VEC[i][8:2]));
      chk("R4 blk_valid after write", 128'(blk_valid), 128'(VEC[i][1]));
      chk("R8 ingress watermark", 128'(in_flags[4]), 128'(VEC[i][0]));
    end
    chk("R1 packed block order", blk_data, BLK_A);
    pop_blk();
    chk("R4 fill after block pop", 128'(in_fill), 128'd0);

    // ingress underrun, stickiness, flush clears
    pop_blk();
    chk("R4 block data zero when empty", blk_data, 128'd0);
    chk("R4 ingress underrun set", 128'(in_flags[6]), 128'd1);
    @(negedge clk); #1;
    chk("R10 underrun stays set", 128'(in_flags[6]), 128'd1);
    flush();
    chk("R10 flags cleared by disable", 128'(in_flags), 128'h19);

    // partial word discarded by disable
    wr(2'd0, 32'h000000AB);
    chk("R2 partial byte counted", 128'(in_fill), 128'd1);
    @(negedge clk); en = 1'b0; #1;
    chk("R12 ready low while disabled", 128'(wr_ready), 128'd0);
    @(negedge clk); en = 1'b1; #1;
    chk("R12 fill zero after disable", 128'(in_fill), 128'd0);
    wr(2'd1, 32'h00002211);
    wr(2'd1, 32'h00004433);
    wr(2'd2, 32'h88776655);
    wr(2'd2, 32'hCCBBAA99);
    wr(2'd2, 32'h00FFEEDD);
    chk("R12 packing restarts at lane 0", blk_data, BLK_A);
    pop_blk();

    // ingress overflow
    for (int i = 0; i < 15; i++) wr(2'd2, 32'h1000 + i);
    wr(2'd1, 32'h0000BEEF);
    chk("R2 fill at 62", 128'(in_fill), 128'd62);
    @(negedge clk); wr_size = 2'd2; #1;
    chk("R3 ready low for word at 62", 128'(wr_ready), 128'd0);
    wr(2'd2, 32'h55555555);
    chk("R3 dropped write keeps fill", 128'(in_fill), 128'd62);
    chk("R3 overflow set", 128'(in_flags[5]), 128'd1);
    wr(2'd1, 32'h0000CAFE);
    chk("R7 full flags", 128'(in_flags), 128'h26);
    chk("R1 overflow block order", blk_data,
        128'h00001003_00001002_00001001_00001000);
    pop_blk();
    chk("R2 fill after pop", 128'(in_fill), 128'd48);

    // ingress DMA
    @(negedge clk); in_dma_en = 1'b1; #1;
    chk("R11 in single at 16 free", 128'(in_dreq_single), 128'd1);
    chk("R11 in burst at 16 free", 128'(in_dreq_burst), 128'd1);
    wr(2'd2, 32'h0);
    chk("R11 in burst off at 12 free", 128'(in_dreq_burst), 128'd0);
    chk("R11 in single at 12 free", 128'(in_dreq_single), 128'd1);
    @(negedge clk); in_dma_burst_only = 1'b1; #1;
    chk("R11 burst-only silences single", 128'(in_dreq_single), 128'd0);
    flush();
    chk("R11 in burst when empty", 128'(in_dreq_burst), 128'd1);
    chk("R11 in single burst-only empty", 128'(in_dreq_single), 128'd0);

    // egress side
    out_dma_en = 1'b1;
    push_res(128'h44444444_33333333_22222222_11111111);
    chk("R2 out fill 16", 128'(out_fill), 128'd16);
    chk("R9 out flags at 16", 128'(out_flags), 128'h1A);
    chk("R11 out burst at 16", 128'(out_dreq_burst), 128'd1);
    rd_one(w); chk("R6 word 0", 128'(w), 128'h11111111);
    chk("R11 out burst off at 12", 128'(out_dreq_burst), 128'd0);
    chk("R11 out single at 12", 128'(out_dreq_single), 128'd1);
    rd_one(w); chk("R6 word 1", 128'(w), 128'h22222222);
    rd_one(w); chk("R6 word 2", 128'(w), 128'h33333333);
    rd_one(w); chk("R6 word 3", 128'(w), 128'h44444444);
    rd_one(w); chk("R6 empty read returns zero", 128'(w), 128'd0);
    chk("R6 egress underrun flags", 128'(out_flags), 128'h49);

    @(negedge clk); out_wm_lvl = 6'd16;
    push_res(128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0);
    chk("R9 watermark off at equal", 128'(out_flags[4]), 128'd0);
    @(negedge clk); out_wm_lvl = 6'd15; #1;
    chk("R9 watermark on above", 128'(out_flags[4]), 128'd1);
    for (int i = 0; i < 3; i++) push_res({4{32'hB0 + 32'(i)}});
    chk("R5 res_ready low at 64", 128'(res_ready), 128'd0);
    push_res({4{32'hDEAD}});
    chk("R5 dropped push keeps fill", 128'(out_fill), 128'd64);
    chk("R5 overflow flags", 128'(out_flags), 128'h76);
    rd_one(w); chk("R6 order after overflow", 128'(w), 128'hA0A0A0A0);
    chk("R5 res_ready at 60", 128'(res_ready), 128'd0);
    flush();
    chk("R12 egress empty after disable", 128'(out_flags), 128'h09);
    chk("R12 rd_valid low after flush", 128'(rd_valid), 128'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule